// File: doc/BRIEF.md
# Segmented Data Address Pointer Unit

This block forms every data-memory address for a small 8-bit processor. An access names its location in one of three ways. It can give a direct 8-bit address. It can go through one of two indirect pointers, each of which may step up or down after it is used. It can go through the stack pointer on a push or a pop. The 8-bit logical address is then widened to a 15-bit physical address. The lower half of the logical space (00–7F) lands in one of 256 segments of 128 bytes, chosen by a segment register. The upper half (80–FF) is the same in every segment.

The pointers sit inside a 15-byte register bank at logical F0–FE. The second indirect pointer is at FC, the stack pointer at FD and the first indirect pointer at FE, so ordinary data writes to those addresses reload them. A register write port, a combinational read port and a decrement-with-zero-test strobe give the rest of the core access to the bank and to the segment register. Instruction decode and arithmetic stay outside the block.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset the stack pointer (read at FD) is 6F hex, and both indirect pointers (FE, FC), the rest of the bank and the segment register (EF) read 00.
- R2: With mode_i = 00 (direct), phys_addr_o is {segment, dir_addr_i[6:0]} when dir_addr_i[7] is 0, and {7'h0, dir_addr_i} when dir_addr_i[7] is 1.
- R3: With mode_i = 01 (indirect), the logical address is the pointer chosen by ptr_sel_i (0 = pointer at FE, 1 = pointer at FC), mapped as in R2, and it uses the value held before the access. When acc_i is high, post_i = 01 adds 1 to that pointer and post_i = 10 subtracts 1, both modulo 256, in the next cycle. post_i = 00 or 11 leaves it unchanged.
- R4: With mode_i = 10 (stack) and acc_i high, a push (push_i only) addresses SP and then decrements SP. A pop (pop_i only) increments SP and addresses the new value. SP wraps modulo 256.
- R5: A write-port write to F0–FE or to EF (segment) lands in the next cycle. A write to FF or to any other address changes nothing.
- R6: rd_data_o shows, in the same cycle, the bank entry or segment addressed by rd_addr_i, and 00 for any other address.
- R7: dsz_i on a bank address F0–FE decrements that entry in the next cycle. dsz_zero_o is high in the same cycle exactly when the entry currently holds 01. dsz_i on any other address does nothing.
- R8: When several updates hit one pointer in a cycle, a write-port write wins over a decrement-with-test, and that wins over a post-update or push/pop.
- R9: In stack mode with push_i and pop_i both high, the address is SP and SP does not change.
- R10: With acc_i low, no post-update, push or pop takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_i | input | 1 | Access strobe; enables pointer side effects |
| mode_i | input | 2 | 00 direct, 01 indirect, 10 stack, 11 direct |
| dir_addr_i | input | 8 | Direct logical address |
| ptr_sel_i | input | 1 | Indirect pointer select: 0 = FE, 1 = FC |
| post_i | input | 2 | Post-update: 01 increment, 10 decrement, else none |
| push_i | input | 1 | Stack push |
| pop_i | input | 1 | Stack pop |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| dsz_i | input | 1 | Decrement-with-zero-test strobe |
| dsz_addr_i | input | 8 | Decrement target address |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Register read data |
| dsz_zero_o | output | 1 | Decrement result will be zero |
| phys_addr_o | output | 15 | Physical data address |

## Verification
The bound checker watches, on every cycle, how direct addresses map for both halves of the space, that a post-increment and a push each move their pointer by exactly one, that a write-port write to a pointer always lands (which covers the priority over post-updates), and that pointers hold still when there is no access. The bench's scenarios are needed for what depends on history or on particular values. These are the reset contents, wrap-around at 00 and FF, pop addressing, the ignored writes to FF and to addresses outside the bank, the zero flag on a count that runs down, and the clash between a decrement and a pop on SP.

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
  parameter int          SEG_W    = 8,
  parameter logic [7:0]  SP_RESET = 8'h6F,
  parameter logic [7:0]  SEG_LOC  = 8'hEF,
  localparam int         PA_W     = SEG_W + 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic [1:0]       mode_i,
  input  logic [7:0]       dir_addr_i,
  input  logic             ptr_sel_i,
  input  logic [1:0]       post_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             dsz_i,
  input  logic [7:0]       dsz_addr_i,
  input  logic [7:0]       rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic             dsz_zero_o,
  output logic [PA_W-1:0]  phys_addr_o
);
  localparam int NREG  = 15;
  localparam int IX_X  = 12;
  localparam int IX_SP = 13;
  localparam int IX_B  = 14;

  function automatic logic in_bank(input logic [7:0] a);
    return (a[7:4] == 4'hF) && (a[3:0] != 4'hF);
  endfunction

  logic [NREG-1:0][7:0] bank_v;
  logic [SEG_W-1:0]     seg_q;
  logic [7:0]           sp_q, b_q, x_q;

  assign sp_q = bank_v[IX_SP];
  assign b_q  = bank_v[IX_B];
  assign x_q  = bank_v[IX_X];

  logic wr_bank, dsz_bank, is_ind, is_stk, push_go, pop_go, ptr_step, post_inc;
  logic [7:0] ptr_val, ptr_nxt, log_addr;

  assign wr_bank  = wr_en_i && in_bank(wr_addr_i);
  assign dsz_bank = dsz_i && in_bank(dsz_addr_i);
  assign is_ind   = (mode_i == 2'b01);
  assign is_stk   = (mode_i == 2'b10);
  assign push_go  = acc_i && is_stk && push_i && !pop_i;
  assign pop_go   = acc_i && is_stk && pop_i && !push_i;
  assign post_inc = (post_i == 2'b01);
  assign ptr_step = acc_i && is_ind && (post_i == 2'b01 || post_i == 2'b10);
  assign ptr_val  = ptr_sel_i ? x_q : b_q;
  assign ptr_nxt  = post_inc ? ptr_val + 8'd1 : ptr_val - 8'd1;

  always_comb begin
    if (is_ind)                      log_addr = ptr_val;
    else if (is_stk && pop_i && !push_i) log_addr = sp_q + 8'd1;
    else if (is_stk)                 log_addr = sp_q;
    else                             log_addr = dir_addr_i;
  end

  assign phys_addr_o = log_addr[7] ? {{(PA_W-8){1'b0}}, log_addr}
                                   : {seg_q, log_addr[6:0]};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] q, nxt;
    logic       load;
    always_comb begin
      load = 1'b1;
      if (wr_bank && wr_addr_i[3:0] == 4'(g))              nxt = wr_data_i;
      else if (dsz_bank && dsz_addr_i[3:0] == 4'(g))       nxt = q - 8'd1;
      else if (g == IX_SP && push_go)                      nxt = q - 8'd1;
      else if (g == IX_SP && pop_go)                       nxt = q + 8'd1;
      else if (g == IX_B && ptr_step && !ptr_sel_i)        nxt = ptr_nxt;
      else if (g == IX_X && ptr_step && ptr_sel_i)         nxt = ptr_nxt;
      else begin
        load = 1'b0;
        nxt  = q;
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q <= (g == IX_SP) ? SP_RESET : 8'h00;
      else if (load) q <= nxt;
    end
    assign bank_v[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                seg_q <= '0;
    else if (wr_en_i && wr_addr_i == SEG_LOC)   seg_q <= wr_data_i[SEG_W-1:0];
  end

  always_comb begin
    if (in_bank(rd_addr_i))        rd_data_o = bank_v[rd_addr_i[3:0]];
    else if (rd_addr_i == SEG_LOC) rd_data_o = 8'(seg_q);
    else                           rd_data_o = 8'h00;
  end

  assign dsz_zero_o = dsz_bank && (bank_v[dsz_addr_i[3:0]] == 8'd1);
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
  parameter int PA_W = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc,
  input logic [1:0]      mode,
  input logic [7:0]      dir_addr,
  input logic            ptr_sel,
  input logic [1:0]      post,
  input logic            push,
  input logic            pop,
  input logic            wr_en,
  input logic [7:0]      wr_addr,
  input logic [7:0]      wr_data,
  input logic            dsz,
  input logic [7:0]      dsz_addr,
  input logic            dsz_zero,
  input logic [PA_W-1:0] phys,
  input logic [7:0]      sp,
  input logic [7:0]      b,
  input logic [7:0]      x
);
  // R2
  dir_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && !dir_addr[7]) |-> phys[6:0] == dir_addr[6:0]);

  // R2
  dir_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && dir_addr[7]) |-> (phys[7:0] == dir_addr && phys[PA_W-1:8] == '0));

  // R3
  b_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 2'b01 && !ptr_sel && post == 2'b01
     && !(wr_en && wr_addr == 8'hFE) && !(dsz && dsz_addr == 8'hFE))
    |=> b == $past(b) + 8'd1);

  // R4
  push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 2'b10 && push && !pop
     && !(wr_en && wr_addr == 8'hFD) && !(dsz && dsz_addr == 8'hFD))
    |=> sp == $past(sp) - 8'd1);

  // R8
  wr_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'hFD) |=> sp == $past(wr_data));

  // R8
  wr_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 8'hFE) |=> b == $past(wr_data));

  // R7
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsz_zero |-> (dsz && dsz_addr[7:4] == 4'hF && dsz_addr[3:0] != 4'hF));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !wr_en && !dsz) |=> ($stable(sp) && $stable(b) && $stable(x)));
endmodule

bind seg_addr_unit seg_addr_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .acc(acc_i), .mode(mode_i), .dir_addr(dir_addr_i),
  .ptr_sel(ptr_sel_i), .post(post_i), .push(push_i), .pop(pop_i),
  .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
  .dsz(dsz_i), .dsz_addr(dsz_addr_i), .dsz_zero(dsz_zero_o),
  .phys(phys_addr_o), .sp(sp_q), .b(b_q), .x(x_q)
);

// File: tb/seg_addr_unit_tb.sv
`timescale 1ns/1ps
module seg_addr_unit_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        acc, ptr_sel, push, pop, wr_en, dsz;
  logic [1:0]  mode, post;
  logic [7:0]  dir_addr, wr_addr, wr_data, dsz_addr, rd_addr, rd_data;
  logic        dsz_zero;
  logic [14:0] phys;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  seg_addr_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .mode_i(mode), .dir_addr_i(dir_addr),
    .ptr_sel_i(ptr_sel), .post_i(post), .push_i(push), .pop_i(pop),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .dsz_i(dsz), .dsz_addr_i(dsz_addr), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .dsz_zero_o(dsz_zero), .phys_addr_o(phys)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    acc = 0; mode = 2'b00; dir_addr = 8'h00; ptr_sel = 0; post = 2'b00;
    push = 0; pop = 0; wr_en = 0; wr_addr = 8'h00; wr_data = 8'h00;
    dsz = 0; dsz_addr = 8'h00; rd_addr = 8'h00;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick(); idle();
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    rd_addr = a; #1; check(tag, rd_data, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 sp reset", 8'hFD, 8'h6F);
    rd_chk("R1 b reset", 8'hFE, 8'h00);
    rd_chk("R1 x reset", 8'hFC, 8'h00);
    rd_chk("R1 seg reset", 8'hEF, 8'h00);
    rd_chk("R1 bank reset", 8'hF3, 8'h00);
  endtask

  task automatic t_direct();
    dir_addr = 8'h12; #1; check("R2 seg0 low", phys, 15'h0012);
    wreg(8'hEF, 8'h5A);
    rd_chk("R5 seg write", 8'hEF, 8'h5A);
    dir_addr = 8'h34; #1; check("R2 seg low", phys, 15'h2D34);
    dir_addr = 8'h7F; #1; check("R2 seg top", phys, 15'h2D7F);
    dir_addr = 8'h80; #1; check("R2 global 80", phys, 15'h0080);
    dir_addr = 8'hC5; #1; check("R2 global C5", phys, 15'h00C5);
    idle();
  endtask

  task automatic t_indirect();
    wreg(8'hFE, 8'h10);
    wreg(8'hFC, 8'hF0);
    acc = 1; mode = 2'b01; ptr_sel = 0; post = 2'b01; #1;
    check("R3 b old addr", phys, 15'h2D10);
    tick(); idle();
    rd_chk("R3 b post inc", 8'hFE, 8'h11);
    acc = 1; mode = 2'b01; ptr_sel = 1; post = 2'b10; #1;
    check("R3 x old addr", phys, 15'h00F0);
    tick(); idle();
    rd_chk("R3 x post dec", 8'hFC, 8'hEF);
    acc = 1; mode = 2'b01; ptr_sel = 0; post = 2'b11; tick(); idle();
    rd_chk("R3 post none", 8'hFE, 8'h11);
    acc = 0; mode = 2'b01; ptr_sel = 0; post = 2'b01; tick(); idle();
    rd_chk("R10 no acc", 8'hFE, 8'h11);
    wreg(8'hFE, 8'hFF);
    acc = 1; mode = 2'b01; ptr_sel = 0; post = 2'b01; tick(); idle();
    rd_chk("R3 wrap", 8'hFE, 8'h00);
  endtask

  task automatic t_stack();
    acc = 1; mode = 2'b10; push = 1; #1;
    check("R4 push addr", phys, 15'h2D6F);
    tick(); idle();
    rd_chk("R4 push sp", 8'hFD, 8'h6E);
    acc = 1; mode = 2'b10; pop = 1; #1;
    check("R4 pop addr", phys, 15'h2D6F);
    tick(); idle();
    rd_chk("R4 pop sp", 8'hFD, 8'h6F);
    acc = 1; mode = 2'b10; push = 1; pop = 1; #1;
    check("R9 both addr", phys, 15'h2D6F);
    tick(); idle();
    rd_chk("R9 both sp", 8'hFD, 8'h6F);
    acc = 0; mode = 2'b10; push = 1; tick(); idle();
    rd_chk("R10 push no acc", 8'hFD, 8'h6F);
    wreg(8'hFD, 8'h00);
    acc = 1; mode = 2'b10; push = 1; #1;
    check("R4 push at 00", phys, 15'h2D00);
    tick(); idle();
    rd_chk("R4 sp wrap down", 8'hFD, 8'hFF);
    acc = 1; mode = 2'b10; pop = 1; #1;
    check("R4 pop to 00", phys, 15'h2D00);
    tick(); idle();
    rd_chk("R4 sp wrap up", 8'hFD, 8'h00);
  endtask

  task automatic t_wrport();
    wreg(8'hF0, 8'h33);
    rd_chk("R5 bank write", 8'hF0, 8'h33);
    wreg(8'hFF, 8'h99);
    rd_chk("R5 FF ignored", 8'hFF, 8'h00);
    rd_chk("R5 FF sp intact", 8'hFD, 8'h00);
    wreg(8'h20, 8'h77);
    rd_chk("R6 outside reads 0", 8'h20, 8'h00);
    rd_chk("R5 outside bank intact", 8'hF0, 8'h33);
  endtask

  task automatic t_dsz();
    wreg(8'hF3, 8'h02);
    dsz = 1; dsz_addr = 8'hF3; #1;
    check("R7 not zero", dsz_zero, 1'b0);
    tick(); idle();
    rd_chk("R7 dec 1", 8'hF3, 8'h01);
    dsz = 1; dsz_addr = 8'hF3; #1;
    check("R7 zero flag", dsz_zero, 1'b1);
    tick(); idle();
    rd_chk("R7 dec 0", 8'hF3, 8'h00);
    wreg(8'hF4, 8'h01);
    dsz = 1; dsz_addr = 8'hFF; #1;
    check("R7 FF no flag", dsz_zero, 1'b0);
    tick(); idle();
    rd_chk("R7 FF no change", 8'hF4, 8'h01);
  endtask

  task automatic t_priority();
    wreg(8'hFE, 8'h40);
    acc = 1; mode = 2'b01; ptr_sel = 0; post = 2'b01;
    wr_en = 1; wr_addr = 8'hFE; wr_data = 8'h77; tick(); idle();
    rd_chk("R8 write over post", 8'hFE, 8'h77);
    dsz = 1; dsz_addr = 8'hFE; wr_en = 1; wr_addr = 8'hFE; wr_data = 8'h10; tick(); idle();
    rd_chk("R8 write over dsz", 8'hFE, 8'h10);
    wreg(8'hFD, 8'h50);
    acc = 1; mode = 2'b10; pop = 1; dsz = 1; dsz_addr = 8'hFD; #1;
    check("R4 pop addr 51", phys, 15'h2D51);
    tick(); idle();
    rd_chk("R8 dsz over pop", 8'hFD, 8'h4F);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_indirect();
    t_stack();
    t_wrport();
    t_dsz();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog got timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule